// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block controls the DRAM row and column strobes during the two periods when the access controller may not use the memory: device initialization after reset, and periodic refresh. After reset it keeps every strobe inactive until a supply settling time has passed. It then runs a fixed number of RAS-only warm-up cycles and raises `init_done`. From that point it counts refresh intervals and runs one CAS-before-RAS cycle per interval. The device's own row counter picks the row, so no address is driven.

The strobes are shared with the access controller through a level handshake. The sequencer raises `req` when it has work waiting and it is idle. A cycle starts only on a clock edge where `gnt` is also high. `busy` stays high from the start of the cycle to the end of its precharge, and an external multiplexer passes the sequencer's strobes to the pins while `busy` is high. The arbiter keeps `gnt` high until `busy` falls.

Refresh demands that arrive while the grant is withheld are counted, not dropped, and are worked off back to back once the grant returns. A sticky flag reports a backlog deeper than the design allows. All times are given in microseconds or clock counts and converted with the clock frequency parameter.

Top module: `dram_init_refresh`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is: `ras_n`, `lcas_n`, `ucas_n` and `we_n` high; `req`, `busy`, `init_done` and `backlog_err` low.
- R2: For the first PWRUP_US*CLK_MHZ clock edges after reset release, `req` stays low and all strobes stay high. `req` rises within a few cycles after that.
- R3: Exactly INIT_CYCLES warm-up cycles run before `init_done` rises. Each warm-up cycle holds `ras_n` low for T_RAS clocks with both CAS strobes high. No CAS-before-RAS cycle occurs before `init_done`.
- R4: A cycle starts only at an edge where `req` and `gnt` are both high. While `gnt` is low and the sequencer is idle, the strobes stay high and `req` stays asserted.
- R5: In a refresh cycle, `lcas_n` and `ucas_n` fall together. `ras_n` falls T_CSR clocks later and stays low for T_RAS clocks. `ras_n` and both CAS strobes return high on the same edge.
- R6: `we_n` is high at all times.
- R7: After every rising edge of `ras_n`, RAS stays high for at least max(T_RP, T_RC-T_RAS) clocks before it can fall again, and `busy` stays high through that precharge.
- R8: Once `init_done` is high, a refresh demand occurs every RETENTION_US*CLK_MHZ/ROWS - MARGIN_CYC clocks. Each demand produces exactly one CAS-before-RAS cycle, even when the grant is delayed across several intervals.
- R9: `backlog_err` rises when more than PEND_MAX refresh demands are outstanding at once. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gnt | input | 1 | Strobe ownership granted by the arbiter |
| req | output | 1 | Sequencer is idle and has a cycle waiting |
| busy | output | 1 | Sequencer owns the strobes (cycle in progress, including precharge) |
| init_done | output | 1 | Power-up wait and warm-up cycles are complete |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| backlog_err | output | 1 | Sticky: outstanding refresh demands exceeded PEND_MAX |

## Verification
The hardest state to reach from the ports is a backlog of several outstanding refresh demands, including one just past the limit. Only the passage of whole refresh intervals with the grant withheld can create it. The bench keeps `gnt` low, waits for a rise of `req` to align to a demand, and then withholds the grant for a computed number of intervals plus a fixed offset, so a known number of demands are pending. It then grants and counts the CAS-before-RAS pulses that follow, before the next demand can arrive. The spacing between successive alignments also measures the refresh period exactly.

// File: rtl/dram_seq_pkg.sv
// Package: shared state encoding and elaboration-time helpers for the
// DRAM power-up and refresh sequencer. Assumes nothing beyond 1800-2017.
package dram_seq_pkg;

    // Strobe sequencer phases: idle, CAS lead, RAS active, precharge.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CSR  = 2'd1,
        ST_RAS  = 2'd2,
        ST_PRE  = 2'd3
    } seq_state_e;

    // Larger of two counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to hold values 0..n-1 (at least one bit).
    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dram_pwrup_gate.sv
// Power-up gate: counts the supply settling time after reset, then counts
// completed warm-up (RAS-only) cycles until INIT_CYCLES have finished.
// Assumes cyc_done pulses once in the last precharge clock of each cycle.
module dram_pwrup_gate
    import dram_seq_pkg::*;
#(
    parameter int unsigned PWRUP_CYC   = 10000,
    parameter int unsigned INIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_done,
    input  logic cyc_was_ref,
    output logic pwr_ok,
    output logic init_done
);
    localparam int unsigned WAIT_W = bits_for(PWRUP_CYC);
    localparam int unsigned INIT_W = bits_for(INIT_CYCLES + 1);

    logic [WAIT_W-1:0] wait_q;
    logic [INIT_W-1:0] init_q;

    // Settling timer: stops counting once the wait has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            pwr_ok <= 1'b0;
        end else if (!pwr_ok) begin
            if (wait_q == WAIT_W'(PWRUP_CYC - 1)) pwr_ok <= 1'b1;
            else wait_q <= wait_q + 1'b1;
        end
    end

    // Warm-up counter: advances on each finished non-refresh cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) init_q <= '0;
        else if (cyc_done && !cyc_was_ref && !init_done) init_q <= init_q + 1'b1;
    end

    assign init_done = (init_q == INIT_W'(INIT_CYCLES));

    // R3: init completes only as a warm-up cycle finishes.
    p_done_on_warmup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(cyc_done && !cyc_was_ref));

    // R2: no cycle may finish before the settling wait has elapsed.
    p_no_cycle_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> !cyc_done);

endmodule

// File: rtl/dram_ref_ticker.sv
// Refresh interval timer: while enabled, emits one tick every INT_CYC clocks.
// Assumes INT_CYC >= 2 and that run stays high once set.
module dram_ref_ticker
    import dram_seq_pkg::*;
#(
    parameter int unsigned INT_CYC = 761
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CNT_W = bits_for(INT_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Free-running interval counter, held at zero until enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (cnt_q == CNT_W'(INT_CYC - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == CNT_W'(INT_CYC - 1));

    // R8: two ticks are never adjacent.
    p_tick_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/dram_ref_backlog.sv
// Refresh backlog: counts refresh demands not yet served. It saturates at
// its full width and sets a sticky error once the count passes PEND_MAX.
// Assumes take only pulses when the count is non-zero.
module dram_ref_backlog
    import dram_seq_pkg::*;
#(
    parameter int unsigned PEND_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    output logic pending_nz,
    output logic backlog_err
);
    localparam int unsigned PEND_W = bits_for(PEND_MAX + 2);
    localparam logic [PEND_W-1:0] PEND_CAP = '1;

    logic [PEND_W-1:0] pend_q;

    // Up on demand, down on service, hold when both or neither.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else begin
            unique case ({tick, take})
                2'b10:   if (pend_q != PEND_CAP) pend_q <= pend_q + 1'b1;
                2'b01:   pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    // Sticky overflow flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) backlog_err <= 1'b0;
        else if (pend_q > PEND_W'(PEND_MAX)) backlog_err <= 1'b1;
    end

    assign pending_nz = (pend_q != '0);

    // R8: a refresh is never taken without a pending demand.
    p_take_has_demand_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pending_nz);

    // R9: the overflow flag never clears outside reset.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        backlog_err |=> backlog_err);

endmodule

// File: rtl/dram_strobe_fsm.sv
// Strobe sequencer: runs one RAS-only or CAS-before-RAS cycle per grant,
// with registered strobes and a timed precharge tail. Assumes want_init and
// want_ref are never high together and that gnt stays high while busy.
module dram_strobe_fsm
    import dram_seq_pkg::*;
#(
    parameter int unsigned T_CSR   = 2,
    parameter int unsigned T_RAS   = 4,
    parameter int unsigned PRE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt,
    input  logic want_init,
    input  logic want_ref,
    output logic req,
    output logic busy,
    output logic take,
    output logic cyc_done,
    output logic cyc_was_ref,
    output logic ras_n,
    output logic cas_n
);
    localparam int unsigned DUR_MAX = max2(max2(T_CSR, T_RAS), PRE_CYC);
    localparam int unsigned DUR_W   = bits_for(DUR_MAX);

    seq_state_e       st_q, st_d;
    logic [DUR_W-1:0] dur_q, dur_d;
    logic             ref_q, ref_d;
    logic             start;
    logic             last;

    assign last  = (dur_q == '0);
    assign req   = (st_q == ST_IDLE) && (want_init || want_ref);
    assign start = req && gnt;
    assign take  = start && want_ref;
    assign busy  = (st_q != ST_IDLE);
    assign cyc_done    = (st_q == ST_PRE) && last;
    assign cyc_was_ref = ref_q;

    // Next-phase selection and per-phase duration loading.
    always_comb begin
        st_d  = st_q;
        dur_d = dur_q;
        ref_d = ref_q;
        unique case (st_q)
            ST_IDLE: if (start) begin
                ref_d = want_ref;
                if (want_ref) begin
                    st_d  = ST_CSR;
                    dur_d = DUR_W'(T_CSR - 1);
                end else begin
                    st_d  = ST_RAS;
                    dur_d = DUR_W'(T_RAS - 1);
                end
            end
            ST_CSR: if (last) begin
                st_d  = ST_RAS;
                dur_d = DUR_W'(T_RAS - 1);
            end else dur_d = dur_q - 1'b1;
            ST_RAS: if (last) begin
                st_d  = ST_PRE;
                dur_d = DUR_W'(PRE_CYC - 1);
            end else dur_d = dur_q - 1'b1;
            ST_PRE: if (last) st_d = ST_IDLE;
                    else dur_d = dur_q - 1'b1;
            default: st_d = ST_IDLE;
        endcase
    end

    // Phase state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            dur_q <= '0;
            ref_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            dur_q <= dur_d;
            ref_q <= ref_d;
        end
    end

    // Registered strobes decoded from the next phase, so pins change with state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
        end else begin
            ras_n <= !(st_d == ST_RAS);
            cas_n <= !(ref_d && ((st_d == ST_CSR) || (st_d == ST_RAS)));
        end
    end

    // R4: ownership is only taken on a granted edge.
    p_start_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(gnt));

    // R5: when RAS falls with CAS low, CAS was already low one clock before.
    p_cas_leads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

    // R5: RAS and CAS return high together.
    p_joint_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> cas_n);

    // R7: the precharge after RAS rises is still owned and RAS stays high.
    p_precharge_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> (ras_n && busy));

endmodule

// File: rtl/dram_init_refresh.sv
// Top: DRAM power-up and refresh sequencer. Gates DRAM use behind a timed
// settling wait and warm-up cycles, then schedules CAS-before-RAS refresh.
// Assumes an arbiter holds gnt high while busy and muxes strobes on busy.
module dram_init_refresh
    import dram_seq_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 50,
    parameter int unsigned PWRUP_US     = 200,
    parameter int unsigned INIT_CYCLES  = 8,
    parameter int unsigned ROWS         = 512,
    parameter int unsigned RETENTION_US = 8000,
    parameter int unsigned MARGIN_CYC   = 20,
    parameter int unsigned T_CSR        = 2,
    parameter int unsigned T_RAS        = 4,
    parameter int unsigned T_RP         = 3,
    parameter int unsigned T_RC         = 6,
    parameter int unsigned PEND_MAX     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt,
    output logic req,
    output logic busy,
    output logic init_done,
    output logic ras_n,
    output logic lcas_n,
    output logic ucas_n,
    output logic we_n,
    output logic backlog_err
);
    localparam int unsigned PWRUP_CYC = PWRUP_US * CLK_MHZ;
    localparam int unsigned REF_INT   = (RETENTION_US * CLK_MHZ) / ROWS - MARGIN_CYC;
    localparam int unsigned PRE_CYC   = max2(T_RP, (T_RC > T_RAS) ? (T_RC - T_RAS) : 1);

    logic pwr_ok;
    logic tick;
    logic take;
    logic pending_nz;
    logic cyc_done;
    logic cyc_was_ref;
    logic want_init;
    logic want_ref;
    logic cas_n;

    assign want_init = pwr_ok && !init_done;
    assign want_ref  = init_done && pending_nz;

    dram_pwrup_gate #(
        .PWRUP_CYC   (PWRUP_CYC),
        .INIT_CYCLES (INIT_CYCLES)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_done    (cyc_done),
        .cyc_was_ref (cyc_was_ref),
        .pwr_ok      (pwr_ok),
        .init_done   (init_done)
    );

    dram_ref_ticker #(
        .INT_CYC (REF_INT)
    ) u_ticker (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (init_done),
        .tick  (tick)
    );

    dram_ref_backlog #(
        .PEND_MAX (PEND_MAX)
    ) u_backlog (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .take        (take),
        .pending_nz  (pending_nz),
        .backlog_err (backlog_err)
    );

    dram_strobe_fsm #(
        .T_CSR   (T_CSR),
        .T_RAS   (T_RAS),
        .PRE_CYC (PRE_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .gnt         (gnt),
        .want_init   (want_init),
        .want_ref    (want_ref),
        .req         (req),
        .busy        (busy),
        .take        (take),
        .cyc_done    (cyc_done),
        .cyc_was_ref (cyc_was_ref),
        .ras_n       (ras_n),
        .cas_n       (cas_n)
    );

    // Both byte strobes share one column strobe; writes are never issued.
    assign lcas_n = cas_n;
    assign ucas_n = cas_n;
    assign we_n   = 1'b1;

    // R2: nothing is requested or strobed during the settling wait.
    p_quiet_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> (ras_n && cas_n && !req));

    // R3: refresh work never appears before initialization completes.
    p_no_refresh_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !take);

endmodule

// File: tb/dram_init_refresh_test.sv
module dram_init_refresh_test;
    localparam int CLK_MHZ      = 50;
    localparam int PWRUP_US     = 1;
    localparam int INIT_CYCLES  = 8;
    localparam int ROWS         = 16;
    localparam int RETENTION_US = 64;
    localparam int MARGIN_CYC   = 20;
    localparam int T_CSR        = 2;
    localparam int T_RAS        = 4;
    localparam int T_RP         = 3;
    localparam int T_RC         = 6;
    localparam int PEND_MAX     = 4;

    localparam int PWRUP_CYC = PWRUP_US * CLK_MHZ;                       // 50
    localparam int REF_INT   = RETENTION_US * CLK_MHZ / ROWS - MARGIN_CYC; // 180
    localparam int PRE_MIN   = (T_RP > T_RC - T_RAS) ? T_RP : T_RC - T_RAS;
    localparam int CYC_LEN   = 1 + T_CSR + T_RAS + PRE_MIN;

    // Table: intervals withheld (backlog depth) and expected error flag.
    localparam int NVEC = 5;
    localparam int VEC_K  [NVEC] = '{1, 2, 4, 3, 5};
    localparam int VEC_ERR[NVEC] = '{0, 0, 0, 0, 1};

    logic clk = 1'b0;
    logic rst_n;
    logic gnt;
    logic req, busy, init_done, ras_n, lcas_n, ucas_n, we_n, backlog_err;

    int n_checks = 0;
    int n_fail   = 0;

    int cyc = 0;
    int n_ref = 0, n_warm = 0, n_we_low = 0, n_split = 0;
    int n_wbad = 0, n_csr_bad = 0, n_late_cas = 0;
    int pre_min = 1000000;
    int lo_run = 0, hi_run = 0, csr_run = 0;
    bit seen_rise = 1'b0;
    logic prev_ras = 1'b1, prev_cas = 1'b1;

    always #10 clk = ~clk;

    dram_init_refresh #(
        .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .INIT_CYCLES(INIT_CYCLES),
        .ROWS(ROWS), .RETENTION_US(RETENTION_US), .MARGIN_CYC(MARGIN_CYC),
        .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC), .PEND_MAX(PEND_MAX)
    ) uut (
        .clk(clk), .rst_n(rst_n), .gnt(gnt), .req(req), .busy(busy),
        .init_done(init_done), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .backlog_err(backlog_err)
    );

    // Pin monitor, sampled between edges.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (we_n !== 1'b1) n_we_low = n_we_low + 1;
        if (lcas_n !== ucas_n) n_split = n_split + 1;
        if (prev_ras && !ras_n) begin
            if (!lcas_n) begin
                n_ref = n_ref + 1;
                if (csr_run != T_CSR) n_csr_bad = n_csr_bad + 1;
            end else n_warm = n_warm + 1;
            if (seen_rise && hi_run < pre_min) pre_min = hi_run;
            lo_run = 1;
        end else if (!ras_n) lo_run = lo_run + 1;
        if (!prev_ras && ras_n) begin
            if (lo_run != T_RAS) n_wbad = n_wbad + 1;
            if (!lcas_n) n_late_cas = n_late_cas + 1;
            hi_run = 1;
            seen_rise = 1'b1;
        end else if (ras_n) hi_run = hi_run + 1;
        if (prev_cas && !lcas_n) csr_run = 1;
        else if (!lcas_n && ras_n) csr_run = csr_run + 1;
        prev_ras = ras_n;
        prev_cas = lcas_n;
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wait_init(input string rq);
        int n = 0;
        while (!init_done && n < 5000) begin
            @(negedge clk);
            n = n + 1;
        end
        check(init_done === 1'b1, rq, int'(init_done), 1);
    endtask

    task automatic check_reset_state();
        check(ras_n === 1'b1 && lcas_n === 1'b1 && ucas_n === 1'b1 && we_n === 1'b1,
              "R1 strobes", int'({ras_n, lcas_n, ucas_n, we_n}), 15);
        check(req === 1'b0 && busy === 1'b0, "R1 req/busy", int'({req, busy}), 0);
        check(init_done === 1'b0 && backlog_err === 1'b0, "R1 flags",
              int'({init_done, backlog_err}), 0);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail = n_fail + 1;
        n_checks = n_checks + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int t_prev;
        int s0;
        rst_n = 1'b0;
        gnt   = 1'b1;
        repeat (4) @(negedge clk);
        check_reset_state();   // R1
        rst_n = 1'b1;

        // R2: quiet settling time, then warm-up.
        repeat (PWRUP_CYC - 2) @(negedge clk);
        check(req === 1'b0 && n_warm == 0, "R2 settle quiet", n_warm, 0);
        wait_init("R3 init_done");
        check(n_warm == INIT_CYCLES, "R3 warm-up count", n_warm, INIT_CYCLES);
        check(n_ref == 0, "R3 no refresh before init", n_ref, 0);
        gnt = 1'b0;

        // R8/R9/R4: backlog table.
        t_prev = 0;
        for (int v = 0; v < NVEC; v++) begin
            int n = 0;
            int c0;
            while (!req && n < 2000) begin
                @(negedge clk);
                n = n + 1;
            end
            if (v > 0)
                check(cyc - t_prev == VEC_K[v-1] * REF_INT, "R8 interval",
                      cyc - t_prev, VEC_K[v-1] * REF_INT);
            t_prev = cyc;
            c0 = n_ref;
            repeat ((VEC_K[v] - 1) * REF_INT + 60) @(negedge clk);
            check(n_ref == c0 && ras_n === 1'b1 && req === 1'b1, "R4 no cycle without gnt",
                  n_ref - c0, 0);
            gnt = 1'b1;
            repeat (VEC_K[v] * CYC_LEN + 20) @(negedge clk);
            check(n_ref - c0 == VEC_K[v], "R8 refreshes served", n_ref - c0, VEC_K[v]);
            check(req === 1'b0, "R8 backlog drained", int'(req), 0);
            check(backlog_err === VEC_ERR[v][0], "R9 backlog flag",
                  int'(backlog_err), VEC_ERR[v]);
            gnt = 1'b0;
        end

        // R9: flag stays set.
        repeat (50) @(negedge clk);
        check(backlog_err === 1'b1, "R9 sticky", int'(backlog_err), 1);

        // R1/R2/R4: reset mid-run, grant withheld after release.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        s0 = n_warm;
        repeat (PWRUP_CYC - 2) @(negedge clk);
        check(req === 1'b0, "R2 req low during settle", int'(req), 0);
        repeat (5) @(negedge clk);
        check(req === 1'b1, "R2 req after settle", int'(req), 1);
        check(n_warm == s0 && ras_n === 1'b1, "R4 held off without gnt", n_warm - s0, 0);
        gnt = 1'b1;
        wait_init("R3 init_done after reset");
        check(n_warm - s0 == INIT_CYCLES, "R3 warm-up count after reset",
              n_warm - s0, INIT_CYCLES);

        // Whole-run pin properties.
        check(n_we_low == 0, "R6 we_n high", n_we_low, 0);
        check(n_split == 0, "R5 byte strobes together", n_split, 0);
        check(n_wbad == 0, "R5 RAS low width", n_wbad, 0);
        check(n_csr_bad == 0, "R5 CAS lead", n_csr_bad, 0);
        check(n_late_cas == 0, "R5 joint release", n_late_cas, 0);
        check(pre_min >= PRE_MIN, "R7 precharge", pre_min, PRE_MIN);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule